// File: doc/BRIEF.md
# Hardware Breakpoint Comparator

This block watches the address and status lines of an emulated processor and compares them against three host-loaded breakpoint registers in every cycle. Each register is 15 bits wide and holds a 12-bit address together with a 3-bit status code, so one register can single out, for example, an instruction fetch from one location or a data write to another. A register takes part in the compare only while its own enable bit is set, and the whole compare runs only while the emulation-mode input is high.

When an enabled register matches, the block sends out a one-cycle synchronization pulse that other debug instruments can use as a trigger. It also reports the index of the matching register; when several registers match in the same cycle, the lowest index wins. When the break-enable input is high, the same event sets a halt request. That request stays set until the host clears it. With break-enable low, the pulse still goes out and emulation keeps running.

Top module: `bkpt_unit`

## Requirements
- R1: After a synchronous reset, `sync_o`, `halt_o` and `hit_idx_o` are 0 and all three breakpoint registers hold 0.
- R2: With `ld_we` high at a clock edge, `ld_data` is stored into the register selected by `ld_sel` (0, 1 or 2). The new value is used for comparisons from the next cycle. `ld_sel` = 3 writes nothing.
- R3: A register matches in a cycle when the 15-bit word {`probe_stat`, `probe_addr`} equals its contents: bits 14:12 against status and bits 11:0 against address. The result appears on the outputs one clock edge after the probe is sampled.
- R4: `sync_o` is high for exactly one cycle at the start of each run of consecutive matching cycles, and is low at all other times.
- R5: While `emu_on` is low, no register matches.
- R6: A register whose `reg_en` bit is 0 never matches, whatever its contents.
- R7: On a matching cycle, `hit_idx_o` takes the lowest index among the matching registers. It holds its value through cycles with no match.
- R8: `halt_o` is set on a cycle in which `sync_o` rises while `brk_en` was high. It then stays high until a cycle with `halt_clr` high and no new halt event. If a set and a clear arrive in the same cycle, the set wins.
- R9: With `brk_en` low, a match still produces the `sync_o` pulse but never sets `halt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Breakpoint register write strobe |
| ld_sel | input | 2 | Register index to write |
| ld_data | input | 15 | Value to write: {status[2:0], address[11:0]} |
| reg_en | input | 3 | Per-register compare enable |
| emu_on | input | 1 | Emulation mode; compare active when high |
| brk_en | input | 1 | Allow a match to raise the halt request |
| halt_clr | input | 1 | Host clear of the halt request |
| probe_addr | input | 12 | Address lines of the emulated processor |
| probe_stat | input | 3 | Status lines of the emulated processor |
| sync_o | output | 1 | One-cycle match pulse for external instruments |
| halt_o | output | 1 | Latched request to halt emulation |
| hit_idx_o | output | 2 | Index of the lowest matching register |

## Verification
Every result is registered once. The pulse, the halt request and the index that follow a probe sampled at one edge are therefore valid just after that edge. A register load affects the compare from the following edge. The bench drives inputs on the falling clock edge and computes the expected state before the rising edge, using the register contents from before any load in that same cycle. It compares all three outputs at the next falling edge. It sweeps every status code over a band of addresses, for all eight enable combinations with break on and off, and then runs a long pseudo-random walk. That walk mixes loads (including the unused index), clears and mode changes.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int ADDR_W   = 12;
    localparam int STAT_W   = 3;
    localparam int NUM_REGS = 3;
    localparam int PROBE_W  = ADDR_W + STAT_W;
    localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    // One compare word: status above address
    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [ADDR_W-1:0] addr;
    } probe_t;

    // Result of the priority stage
    typedef struct packed {
        logic             any;
        logic [SEL_W-1:0] idx;
    } hit_t;

    function automatic probe_t pack_probe(input logic [STAT_W-1:0] s,
                                          input logic [ADDR_W-1:0] a);
        probe_t p;
        p.stat = s;
        p.addr = a;
        return p;
    endfunction

    function automatic logic probe_eq(input probe_t a, input probe_t b);
        return (a.stat == b.stat) && (a.addr == b.addr);
    endfunction

endpackage

// File: rtl/bkpt_reg_bank.sv
module bkpt_reg_bank
    import bkpt_pkg::*;
#(
    parameter int N  = NUM_REGS,
    parameter int SW = SEL_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ld_we,
    input  logic [SW-1:0]          ld_sel,
    input  probe_t                 ld_data,
    output probe_t [N-1:0]         regs_o
);

    probe_t [N-1:0] regs_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs_q[i] <= '0;
                end else if (ld_we && (int'(ld_sel) == i)) begin
                    regs_q[i] <= ld_data;
                end
            end

            // r2_: a write to another index leaves this register alone
            p_keep_r2: assert property (@(posedge clk) disable iff (rst)
                !(ld_we && int'(ld_sel) == i) |=> $stable(regs_q[i]));
        end
    endgenerate

    assign regs_o = regs_q;

endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
    import bkpt_pkg::*;
#(
    parameter int N = NUM_REGS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   emu_on,
    input  logic [N-1:0]           reg_en,
    input  probe_t                 probe,
    input  probe_t [N-1:0]         regs,
    output logic [N-1:0]           hits
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_cmp
            assign hits[i] = emu_on && reg_en[i] && probe_eq(regs[i], probe);

            // R6: a disabled slot reports no hit
            p_dis_nohit_r6: assert property (@(posedge clk) disable iff (rst)
                !reg_en[i] |-> !hits[i]);
        end
    endgenerate

    // R5: outside emulation mode nothing matches
    p_off_nohit_r5: assert property (@(posedge clk) disable iff (rst)
        !emu_on |-> (hits == '0));

endmodule

// File: rtl/bkpt_prio.sv
module bkpt_prio
    import bkpt_pkg::*;
#(
    parameter int N  = NUM_REGS,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  hits,
    output hit_t          result
);

    always_comb begin
        result.any = |hits;
        result.idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                result.idx = SW'(i);
            end
        end
    end

    // R7: the reported slot is a real hit and none below it hit
    p_idx_valid_r7: assert property (@(posedge clk) disable iff (rst)
        result.any |-> hits[result.idx]);
    p_idx_lowest_r7: assert property (@(posedge clk) disable iff (rst)
        result.any |-> ((hits & ((N'(1) << result.idx) - N'(1))) == '0));

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int N  = NUM_REGS,
    parameter int SW = SEL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_we,
    input  logic [SW-1:0]        ld_sel,
    input  logic [PROBE_W-1:0]   ld_data,
    input  logic [N-1:0]         reg_en,
    input  logic                 emu_on,
    input  logic                 brk_en,
    input  logic                 halt_clr,
    input  logic [ADDR_W-1:0]    probe_addr,
    input  logic [STAT_W-1:0]    probe_stat,
    output logic                 sync_o,
    output logic                 halt_o,
    output logic [SW-1:0]        hit_idx_o
);

    probe_t [N-1:0] regs;
    logic   [N-1:0] hits;
    hit_t           hit;
    probe_t         probe;

    logic           prev_q;
    logic           sync_q;
    logic           halt_q;
    logic [SW-1:0]  idx_q;
    logic           new_hit;

    assign probe = pack_probe(probe_stat, probe_addr);

    bkpt_reg_bank #(.N(N), .SW(SW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .ld_we   (ld_we),
        .ld_sel  (ld_sel),
        .ld_data (probe_t'(ld_data)),
        .regs_o  (regs)
    );

    bkpt_cmp #(.N(N)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .emu_on (emu_on),
        .reg_en (reg_en),
        .probe  (probe),
        .regs   (regs),
        .hits   (hits)
    );

    bkpt_prio #(.N(N), .SW(SW)) u_prio (
        .clk    (clk),
        .rst    (rst),
        .hits   (hits),
        .result (hit)
    );

    // Start of a run of matching cycles
    assign new_hit = hit.any && !prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            sync_q <= 1'b0;
            halt_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            prev_q <= hit.any;
            sync_q <= new_hit;
            halt_q <= (new_hit && brk_en) || (halt_q && !halt_clr);
            if (hit.any) begin
                idx_q <= hit.idx;
            end
        end
    end

    assign sync_o    = sync_q;
    assign halt_o    = halt_q;
    assign hit_idx_o = idx_q;

    // R4: the pulse never lasts two cycles
    p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        sync_o |=> !sync_o);
    // R5: no pulse follows a cycle outside emulation
    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !emu_on |=> !sync_o);
    // R8: the request holds until the host clears it
    p_halt_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (halt_o && !halt_clr) |=> halt_o);
    // R9: the request rises only alongside a pulse with break allowed
    p_halt_src_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_o) |-> (sync_o && $past(brk_en)));
    // R7: the index changes only after a matching cycle
    p_idx_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !hit.any |=> $stable(hit_idx_o));

endmodule

// File: tb/tb_bkpt_unit.sv
module tb_bkpt_unit;

    localparam int CLK_PERIOD = 10;
    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_we;
    logic [1:0]  ld_sel;
    logic [14:0] ld_data;
    logic [2:0]  reg_en;
    logic        emu_on;
    logic        brk_en;
    logic        halt_clr;
    logic [11:0] probe_addr;
    logic [2:0]  probe_stat;
    logic        sync_o;
    logic        halt_o;
    logic [1:0]  hit_idx_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // bench model state
    logic [14:0] m_reg [N];
    logic        m_prev;
    logic        m_halt;
    logic [1:0]  m_idx;
    logic        e_sync;
    logic [31:0] lcg;

    always #(CLK_PERIOD/2) clk = ~clk;

    bkpt_unit dut (
        .clk(clk), .rst(rst), .ld_we(ld_we), .ld_sel(ld_sel), .ld_data(ld_data),
        .reg_en(reg_en), .emu_on(emu_on), .brk_en(brk_en), .halt_clr(halt_clr),
        .probe_addr(probe_addr), .probe_stat(probe_stat),
        .sync_o(sync_o), .halt_o(halt_o), .hit_idx_o(hit_idx_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // One cycle: model the edge from current inputs, clock it, compare outputs
    task automatic tick();
        logic        hit_now;
        logic [1:0]  idx_now;
        logic [14:0] word;
        word    = {probe_stat, probe_addr};
        hit_now = 1'b0;
        idx_now = 2'd0;
        for (int i = N - 1; i >= 0; i--) begin
            if (emu_on && reg_en[i] && m_reg[i] == word) begin
                hit_now = 1'b1;
                idx_now = 2'(i);
            end
        end
        e_sync = hit_now && !m_prev;
        m_prev = hit_now;
        if (hit_now) m_idx = idx_now;
        m_halt = (e_sync && brk_en) || (m_halt && !halt_clr);
        if (ld_we && ld_sel < 2'd3) m_reg[ld_sel] = ld_data;
        @(posedge clk);
        @(negedge clk);
        chk("R3/R4/R5/R6 sync_o", int'(sync_o), int'(e_sync));
        chk("R8/R9 halt_o", int'(halt_o), int'(m_halt));
        chk("R7 hit_idx_o", int'(hit_idx_o), int'(m_idx));
    endtask

    task automatic load(input logic [1:0] sel, input logic [14:0] val);
        ld_we   = 1'b1;
        ld_sel  = sel;
        ld_data = val;
        tick();   // R2: load
        ld_we   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        lcg = 32'h1234_5678;
        rst = 1'b1; ld_we = 0; ld_sel = 0; ld_data = 0; reg_en = 0;
        emu_on = 0; brk_en = 0; halt_clr = 0; probe_addr = 0; probe_stat = 0;
        for (int i = 0; i < N; i++) m_reg[i] = '0;
        m_prev = 0; m_halt = 0; m_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 sync_o", int'(sync_o), 0);
        chk("R1 halt_o", int'(halt_o), 0);
        chk("R1 hit_idx_o", int'(hit_idx_o), 0);
        // R1: registers cleared, so word 0 hits slot 0 once enabled
        reg_en = 3'b001; emu_on = 1;
        tick();
        chk("R1 zero register match", int'(sync_o), 1);
        emu_on = 0; reg_en = 0;
        tick();

        // R2: loads; slot 2 duplicates slot 0 to exercise priority
        load(2'd0, {3'b001, 12'h0A5});
        load(2'd1, {3'b100, 12'h0A5});
        load(2'd2, {3'b001, 12'h0A5});
        load(2'd3, {3'b111, 12'h0A7});   // R2: index 3 writes nothing

        // Near-exhaustive sweep: enables x break x status x address band
        emu_on = 1;
        for (int b = 0; b < 2; b++) begin
            for (int en = 0; en < 8; en++) begin
                reg_en = 3'(en);
                brk_en = b[0];
                halt_clr = 1'b1;
                probe_addr = 12'hFFF; probe_stat = 3'b000;
                tick();
                halt_clr = 1'b0;
                for (int s = 0; s < 8; s++) begin
                    for (int a = 12'h0A0; a < 12'h0B0; a++) begin
                        probe_stat = 3'(s);
                        probe_addr = 12'(a);
                        tick();
                    end
                end
                // R4: hold a matching probe for several cycles
                probe_stat = 3'b100; probe_addr = 12'h0A5;
                repeat (4) tick();
            end
        end

        // R5: matching probe outside emulation
        emu_on = 0; reg_en = 3'b111;
        repeat (3) tick();
        chk("R5 no pulse when idle", int'(sync_o), 0);

        // Pseudo-random walk
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r;
            r = rnd();
            ld_we    = (r[3:0] == 4'd0);
            ld_sel   = r[5:4];
            ld_data  = {r[8:6], 8'h00, r[12:9]};
            reg_en   = r[15:13];
            emu_on   = (r[17:16] != 2'd0);
            brk_en   = r[18];
            halt_clr = (r[22:19] == 4'd0);
            if (r[23]) begin
                probe_stat = m_reg[r[25:24] % 3][14:12];
                probe_addr = m_reg[r[25:24] % 3][11:0];
            end else begin
                probe_stat = r[8:6];
                probe_addr = {8'h00, r[29:26]};
            end
            tick();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule